// File: doc/BRIEF.md
# Byte-Wide Bus-Mapped Digital I/O Port

This block gives a processor eight general-purpose digital pins through three byte registers that sit in its data address space. The direction register decides which pins are driven and which are inputs. The level register holds the value driven on output pins. The pin register returns the pad levels after synchronisation to the bus clock. A write of ones to the pin register inverts the matching level bits, so software can flip pins with a single store and without a read-modify-write sequence.

Accesses use a plain single-cycle bus with select, write strobe, address and write data. Read data is combinational and valid in the cycle that the read is presented. The block decodes a four-byte window at the parameter `BASE`, which must be a multiple of four. Further ports are made by instantiating the block again at another base address.

Top module: `gpio_port`

## Requirements
- R1: After reset the direction and level registers are zero, so `pad_oe_o` and `pad_o` are all zero and every pin is an undriven input.
- R2: A write to offset 1 (direction) loads `wdata_i` into the direction register, and `pad_oe_o` equals the direction register from the next clock. A 1 bit makes the pin an output.
- R3: A write to offset 2 (level) loads `wdata_i` into the level register, and `pad_o` equals it from the next clock.
- R4: A read at offset 1 or offset 2 returns the value last written to that register.
- R5: A read at offset 0 (pins) returns `pad_i` as it was two clock edges earlier. A pad change becomes visible after two rising edges.
- R6: A write to offset 0 inverts each level bit whose `wdata_i` bit is 1. Level bits whose `wdata_i` bit is 0 keep their value, and the direction register does not change.
- R7: An access outside the window `BASE` to `BASE+3`, or at offset 3, changes no register. A read of such an address returns zero.
- R8: While `sel_i` is low, no register changes, whatever the other bus inputs are.
- R9: `rdata_o` is zero in any cycle that is not a read (`sel_i` low or `we_i` high).

Offsets are relative to `BASE` and use address bits [1:0].

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Bus and register clock |
| rst_ni | input | 1 | Active-low asynchronous reset |
| sel_i | input | 1 | Bus access valid this cycle |
| we_i | input | 1 | 1 = write, 0 = read |
| addr_i | input | ADDR_W (8) | Byte address |
| wdata_i | input | WIDTH (8) | Write data |
| rdata_o | output | WIDTH (8) | Read data, valid in the cycle the read is presented |
| pad_i | input | WIDTH (8) | Pad input levels, asynchronous |
| pad_o | output | WIDTH (8) | Pad output levels |
| pad_oe_o | output | WIDTH (8) | Pad output enables |

## Verification
A corrupted direction or level bit shows on `pad_oe_o` or `pad_o` one clock after the write that caused it, and every register readback exposes it as well. A broken toggle path shows as a wrong `pad_o` bit right after the pin-register write. A synchroniser with the wrong depth shows as a pin read that changes one edge too early or too late. Decoding errors show as register changes, or as nonzero read data, after accesses outside the window.

// File: rtl/gpio_pkg.sv
package gpio_pkg;
  typedef enum logic [1:0] {
    OFS_PIN  = 2'd0,
    OFS_DIR  = 2'd1,
    OFS_LVL  = 2'd2,
    OFS_NONE = 2'd3
  } gpio_ofs_e;

  typedef struct packed {
    logic wr_dir;
    logic wr_lvl;
    logic wr_tgl;
    logic rd_pin;
    logic rd_dir;
    logic rd_lvl;
  } gpio_acc_t;
endpackage

// File: rtl/gpio_decode.sv
module gpio_decode
  import gpio_pkg::*;
#(
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 32'h20
) (
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  output gpio_acc_t         acc_o
);
  localparam logic [ADDR_W-1:0] BASE_V = ADDR_W'(BASE);
  localparam int unsigned       HI     = ADDR_W - 1;

  logic      hit;
  gpio_ofs_e ofs;

  assign hit = sel_i && (addr_i[HI:2] == BASE_V[HI:2]);
  assign ofs = gpio_ofs_e'(addr_i[1:0]);

  always_comb begin
    acc_o = '0;
    if (hit) begin
      unique case (ofs)
        OFS_PIN: begin acc_o.wr_tgl = we_i; acc_o.rd_pin = !we_i; end
        OFS_DIR: begin acc_o.wr_dir = we_i; acc_o.rd_dir = !we_i; end
        OFS_LVL: begin acc_o.wr_lvl = we_i; acc_o.rd_lvl = !we_i; end
        default: acc_o = '0;
      endcase
    end
  end
endmodule

// File: rtl/gpio_regs.sv
module gpio_regs
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH = 8
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  gpio_acc_t        acc_i,
  input  logic [WIDTH-1:0] wdata_i,
  output logic [WIDTH-1:0] dir_o,
  output logic [WIDTH-1:0] lvl_o
);
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      dir_o <= '0;
      lvl_o <= '0;
    end else begin
      if (acc_i.wr_dir) dir_o <= wdata_i;
      // one address per access: direct write and toggle are exclusive
      if (acc_i.wr_lvl)      lvl_o <= wdata_i;
      else if (acc_i.wr_tgl) lvl_o <= lvl_o ^ wdata_i;
    end
  end
endmodule

// File: rtl/gpio_sync.sv
module gpio_sync #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned STAGES = 2
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic [WIDTH-1:0] async_i,
  output logic [WIDTH-1:0] sync_o
);
  for (genvar b = 0; b < WIDTH; b++) begin : g_bit
    logic [STAGES-1:0] chain;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) chain <= '0;
      else         chain <= {chain[STAGES-2:0], async_i[b]};
    end
    assign sync_o[b] = chain[STAGES-1];
  end
endmodule

// File: rtl/gpio_port.sv
module gpio_port
  import gpio_pkg::*;
#(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 32'h20,
  parameter int unsigned SYNC_N = 2
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              sel_i,
  input  logic              we_i,
  input  logic [ADDR_W-1:0] addr_i,
  input  logic [WIDTH-1:0]  wdata_i,
  output logic [WIDTH-1:0]  rdata_o,
  input  logic [WIDTH-1:0]  pad_i,
  output logic [WIDTH-1:0]  pad_o,
  output logic [WIDTH-1:0]  pad_oe_o
);
  gpio_acc_t        acc;
  logic [WIDTH-1:0] dir_q, lvl_q, pin_s;

  gpio_decode #(.ADDR_W(ADDR_W), .BASE(BASE)) u_dec (
    .sel_i (sel_i),
    .we_i  (we_i),
    .addr_i(addr_i),
    .acc_o (acc)
  );

  gpio_regs #(.WIDTH(WIDTH)) u_regs (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .acc_i  (acc),
    .wdata_i(wdata_i),
    .dir_o  (dir_q),
    .lvl_o  (lvl_q)
  );

  gpio_sync #(.WIDTH(WIDTH), .STAGES(SYNC_N)) u_sync (
    .clk_i  (clk_i),
    .rst_ni (rst_ni),
    .async_i(pad_i),
    .sync_o (pin_s)
  );

  always_comb begin
    rdata_o = '0;
    if (acc.rd_pin) rdata_o = pin_s;
    if (acc.rd_dir) rdata_o = dir_q;
    if (acc.rd_lvl) rdata_o = lvl_q;
  end

  assign pad_o    = lvl_q;
  assign pad_oe_o = dir_q;
endmodule

// File: rtl/gpio_port_chk.sv
module gpio_port_chk #(
  parameter int unsigned WIDTH  = 8,
  parameter int unsigned ADDR_W = 8,
  parameter int unsigned BASE   = 32'h20
) (
  input logic              clk_i,
  input logic              rst_ni,
  input logic              sel_i,
  input logic              we_i,
  input logic [ADDR_W-1:0] addr_i,
  input logic [WIDTH-1:0]  wdata_i,
  input logic [WIDTH-1:0]  rdata_o,
  input logic [WIDTH-1:0]  pad_o,
  input logic [WIDTH-1:0]  pad_oe_o
);
  localparam logic [ADDR_W-1:0] A_PIN = ADDR_W'(BASE);
  localparam logic [ADDR_W-1:0] A_DIR = ADDR_W'(BASE + 1);
  localparam logic [ADDR_W-1:0] A_LVL = ADDR_W'(BASE + 2);

  logic wr_pin, wr_dir, wr_lvl, wr_other;
  assign wr_pin   = sel_i && we_i && addr_i == A_PIN;
  assign wr_dir   = sel_i && we_i && addr_i == A_DIR;
  assign wr_lvl   = sel_i && we_i && addr_i == A_LVL;
  assign wr_other = sel_i && we_i && !(wr_pin || wr_dir || wr_lvl);

  p_dir_write_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_dir |=> pad_oe_o == $past(wdata_i));
  p_lvl_write_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_lvl |=> pad_o == $past(wdata_i));
  p_toggle_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_pin |=> (pad_o == ($past(pad_o) ^ $past(wdata_i))) && $stable(pad_oe_o));
  p_outside_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    wr_other |=> $stable(pad_o) && $stable(pad_oe_o));
  p_idle_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !sel_i |=> $stable(pad_o) && $stable(pad_oe_o));
  p_rdata_quiet_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!sel_i || we_i) |-> rdata_o == '0);
endmodule

bind gpio_port gpio_port_chk #(.WIDTH(WIDTH), .ADDR_W(ADDR_W), .BASE(BASE)) u_chk (
  .clk_i   (clk_i),
  .rst_ni  (rst_ni),
  .sel_i   (sel_i),
  .we_i    (we_i),
  .addr_i  (addr_i),
  .wdata_i (wdata_i),
  .rdata_o (rdata_o),
  .pad_o   (pad_o),
  .pad_oe_o(pad_oe_o)
);

// File: tb/gpio_port_test.sv
module gpio_port_test;
  localparam int W = 8;
  localparam int A = 8;
  localparam logic [7:0] B = 8'h20;

  logic         clk = 0, rst_n = 0;
  logic         sel = 0, we = 0;
  logic [A-1:0] addr = '0;
  logic [W-1:0] wdata = '0, rdata, pad_in = '0, pad_out, pad_oe;

  int checks = 0, errors = 0;
  bit done = 0;
  logic [W-1:0] exp_q[$];
  string        tag_q[$];

  always #10 clk = ~clk;

  gpio_port #(.WIDTH(W), .ADDR_W(A), .BASE(32'h20)) uut (
    .clk_i(clk), .rst_ni(rst_n), .sel_i(sel), .we_i(we), .addr_i(addr),
    .wdata_i(wdata), .rdata_o(rdata), .pad_i(pad_in), .pad_o(pad_out),
    .pad_oe_o(pad_oe)
  );

  task automatic check(input logic [W-1:0] act, input logic [W-1:0] exp, input string tag);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %02h expected %02h", tag, act, exp);
    end
  endtask

  // all bus tasks start and end just after a rising edge
  task automatic bus_wr(input logic [A-1:0] a, input logic [W-1:0] d);
    sel = 1; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    sel = 0; we = 0;
  endtask

  task automatic bus_rd(input logic [A-1:0] a, input logic [W-1:0] exp, input string tag);
    sel = 1; we = 0; addr = a;
    exp_q.push_back(exp); tag_q.push_back(tag);
    @(posedge clk); #1;
    sel = 0;
  endtask

  task automatic idle_junk(input logic [A-1:0] a, input logic [W-1:0] d);
    sel = 0; we = 1; addr = a; wdata = d;
    @(posedge clk); #1;
    we = 0;
  endtask

  // monitor: scoreboard pop on every read, quiet bus otherwise
  always @(negedge clk) begin
    if (rst_n && sel && !we) begin
      if (exp_q.size() == 0) begin
        checks++; errors++;
        $display("FAIL scoreboard: unexpected read, actual %02h expected none", rdata);
      end else begin
        check(rdata, exp_q.pop_front(), tag_q.pop_front());
      end
    end else if (rst_n) begin
      if (rdata !== '0) begin
        checks++; errors++;
        $display("FAIL R9: actual %02h expected 00", rdata);
      end
    end
  end

  initial begin
    #3_000_000;
    if (!done) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(posedge clk); #1;

    // R1 reset state
    check(pad_oe, 8'h00, "R1 oe");
    check(pad_out, 8'h00, "R1 out");
    bus_rd(B + 1, 8'h00, "R1 dir");
    bus_rd(B + 2, 8'h00, "R1 lvl");

    // R2 direction
    bus_wr(B + 1, 8'hA5);
    check(pad_oe, 8'hA5, "R2 oe");
    bus_wr(B + 1, 8'h3C);
    check(pad_oe, 8'h3C, "R2 oe second");

    // R3 level
    bus_wr(B + 2, 8'h96);
    check(pad_out, 8'h96, "R3 out");

    // R4 readback
    bus_rd(B + 1, 8'h3C, "R4 dir");
    bus_rd(B + 2, 8'h96, "R4 lvl");

    // R6 toggle
    bus_wr(B + 0, 8'h0F);
    check(pad_out, 8'h99, "R6 toggle");
    bus_wr(B + 0, 8'h00);
    check(pad_out, 8'h99, "R6 zero no effect");
    check(pad_oe, 8'h3C, "R6 dir untouched");
    bus_wr(B + 0, 8'hFF);
    check(pad_out, 8'h66, "R6 all");
    bus_rd(B + 2, 8'h66, "R6 readback");

    // R5 pin latency
    pad_in = 8'h5A;
    bus_rd(B + 0, 8'h00, "R5 before edge one");
    bus_rd(B + 0, 8'h00, "R5 after one edge");
    bus_rd(B + 0, 8'h5A, "R5 after two edges");
    pad_in = 8'hC3;
    @(posedge clk); #1;
    @(posedge clk); #1;
    bus_rd(B + 0, 8'hC3, "R5 second pattern");

    // R7 outside window and offset 3
    bus_wr(B + 3, 8'hFF);
    bus_wr(B + 4, 8'h11);
    bus_wr(B - 1, 8'h22);
    bus_wr(8'hA1, 8'h33);
    check(pad_out, 8'h66, "R7 lvl kept");
    check(pad_oe, 8'h3C, "R7 dir kept");
    bus_rd(B + 3, 8'h00, "R7 offset3 read");
    bus_rd(B + 5, 8'h00, "R7 outside read");
    bus_rd(8'hA2, 8'h00, "R7 alias read");

    // R8 sel low
    idle_junk(B + 1, 8'hFF);
    idle_junk(B + 2, 8'h01);
    idle_junk(B + 0, 8'hFF);
    check(pad_oe, 8'h3C, "R8 dir kept");
    check(pad_out, 8'h66, "R8 lvl kept");

    // R9 quiet read data covered by monitor; explicit write-cycle check
    sel = 1; we = 1; addr = B + 1; wdata = 8'hC0;
    #2 check(rdata, 8'h00, "R9 during write");
    @(posedge clk); #1; sel = 0; we = 0;
    check(pad_oe, 8'hC0, "R2 oe third");

    @(posedge clk); #1;
    if (exp_q.size() != 0) begin
      checks++; errors++;
      $display("FAIL scoreboard: actual %0d pending expected 0", exp_q.size());
    end
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule